// File: doc/BRIEF.md
# External Interrupt Trigger Conditioner

This block turns four asynchronous external interrupt pins into clean, clock-domain request lines. Each pin first crosses into the clock domain through a synchronizer. A per-source trigger mode then decides how the pin becomes a request. The mode can be the pin level as it is, the pin level inverted, a captured rising transition, or a captured falling transition. Captured transitions stay pending until software acknowledges them.

Software sets the trigger modes with a single 32-bit configuration write, which holds one 2-bit field per source. It acknowledges captured transitions by writing ones to a separate clear register. Each source's request is gated by its bit of an enable mask. Prioritising and vectoring the requests is left to the logic downstream.

Top module: `irq_trigger_cond`

## Requirements
- R1: After reset the configuration holds zero, so every source is in high-level mode. With all pins low, no request is asserted.
- R2: The trigger mode of source i sits in configuration bits [2i+1:2i]. Configuration bits 31:8 have no effect on any request.
- R3: In mode 00 (high level), request i equals pin i as it was two clock edges earlier, through the two-stage synchronizer.
- R4: In mode 01 (low level), request i equals the inverse of pin i as it was two clock edges earlier.
- R5: In mode 10 (rising edge), a 0-to-1 pin transition sets request i on the third clock edge after the change. The request stays set after the pin falls again.
- R6: In mode 11 (falling edge), a 1-to-0 pin transition sets request i on the third clock edge after the change. The request stays set after the pin rises again.
- R7: A clear write with bit i set drops the captured request of edge-mode source i at that clock edge. Sources whose clear bit is 0 keep their captured request.
- R8: A clear write has no effect on a source in a level mode.
- R9: If a transition is detected in the same cycle as a clear write for that source, the captured request stays set.
- R10: A configuration write that changes source i's mode drops its captured request. Switching into an edge mode while the pin is steady reports no request. A write that leaves the field unchanged keeps the captured request.
- R11: Request i is low whenever enable bit i is 0. A transition captured while the source is disabled appears as soon as the enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 4 | Asynchronous external interrupt pins |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgWrData | input | 32 | Configuration write data; 2-bit trigger mode per source |
| clrWrEn | input | 1 | Clear register write strobe |
| clrWrData | input | 32 | Clear write data; bit i acknowledges source i |
| enMask | input | 4 | Per-source request enable |
| irqReq | output | 4 | Conditioned interrupt requests |

## Verification
A corrupted synchronizer or previous-value flop shows up at the ports within three clock edges of a pin change. It appears as a request that arrives one cycle early or late, or as a spurious request after a mode switch. A capture latch that is stuck or wrongly cleared is exposed at the next clear write or configuration rewrite, because the request persists or vanishes against the expected pattern. The same latch is also checked by re-enabling a source that was masked while it captured. Because the enable gating is combinational, a wrong enable path shows in the same cycle the mask changes.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int NUM_SRC = 4;
  localparam int FIELD_W = 2;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_SRC-1:0] dropLatch;  // mode changed: forget captured edge
    logic [NUM_SRC-1:0] clrHit;     // software acknowledge
  } ctrl_strb_t;
endpackage

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import irq_trig_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cfgWrEn,
  input  logic [REG_W-1:0]                  cfgWrData,
  input  logic                              clrWrEn,
  input  logic [REG_W-1:0]                  clrWrData,
  output logic [NUM_SRC-1:0][FIELD_W-1:0]   modeQ,
  output ctrl_strb_t                        strb
);
  localparam int CFG_BITS = NUM_SRC * FIELD_W;

  logic [CFG_BITS-1:0] cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWrEn) cfgQ <= cfgWrData[CFG_BITS-1:0];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign modeQ[g] = cfgQ[g*FIELD_W +: FIELD_W];
    assign strb.dropLatch[g] = cfgWrEn &&
        (cfgWrData[g*FIELD_W +: FIELD_W] != cfgQ[g*FIELD_W +: FIELD_W]);
    assign strb.clrHit[g] = clrWrEn && clrWrData[g];
  end

  // Reserved upper bits are deliberately ignored
  if (REG_W > CFG_BITS) begin : g_rsvd_cfg
    logic unusedCfgHi;
    assign unusedCfgHi = ^cfgWrData[REG_W-1:CFG_BITS];
  end
  if (REG_W > NUM_SRC) begin : g_rsvd_clr
    logic unusedClrHi;
    assign unusedClrHi = ^clrWrData[REG_W-1:NUM_SRC];
  end
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import irq_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_SRC-1:0]               pinIn,
  input  logic [NUM_SRC-1:0][FIELD_W-1:0]  modeQ,
  input  ctrl_strb_t                       strb,
  input  logic [NUM_SRC-1:0]               enMask,
  output logic [NUM_SRC-1:0]               irqReq
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   pinState;
    logic                   prevQ;
    logic                   latchQ;
    logic                   edgeHit;
    logic                   rawReq;
    trig_mode_e             mode;

    assign mode     = trig_mode_e'(modeQ[g]);
    assign pinState = syncChain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain <= '0;
        prevQ     <= 1'b0;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn[g]};
        prevQ     <= pinState;
      end
    end

    always_comb begin
      edgeHit = 1'b0;
      rawReq  = 1'b0;
      case (mode)
        TRIG_HIGH: rawReq = pinState;
        TRIG_LOW:  rawReq = ~pinState;
        TRIG_RISE: begin
          edgeHit = pinState & ~prevQ;
          rawReq  = latchQ;
        end
        TRIG_FALL: begin
          edgeHit = ~pinState & prevQ;
          rawReq  = latchQ;
        end
        default: rawReq = 1'b0;
      endcase
    end

    // Mode change wins, then a fresh edge, then the acknowledge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) latchQ <= 1'b0;
      else if (strb.dropLatch[g]) latchQ <= 1'b0;
      else if (edgeHit) latchQ <= 1'b1;
      else if (strb.clrHit[g]) latchQ <= 1'b0;
    end

    assign irqReq[g] = enMask[g] & rawReq;
  end
endmodule

// File: rtl/irq_trigger_cond.sv
module irq_trigger_cond
  import irq_trig_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pinIn,
  input  logic               cfgWrEn,
  input  logic [REG_W-1:0]   cfgWrData,
  input  logic               clrWrEn,
  input  logic [REG_W-1:0]   clrWrData,
  input  logic [NUM_SRC-1:0] enMask,
  output logic [NUM_SRC-1:0] irqReq
);
  logic [NUM_SRC-1:0][FIELD_W-1:0] modeQ;
  ctrl_strb_t                      strb;

  trig_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .clrWrEn   (clrWrEn),
    .clrWrData (clrWrData),
    .modeQ     (modeQ),
    .strb      (strb)
  );

  trig_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .modeQ  (modeQ),
    .strb   (strb),
    .enMask (enMask),
    .irqReq (irqReq)
  );
endmodule

// File: rtl/irq_trigger_cond_chk.sv
module irq_trigger_cond_chk
  import irq_trig_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] pinIn,
  input logic               cfgWrEn,
  input logic [31:0]        cfgWrData,
  input logic               clrWrEn,
  input logic [31:0]        clrWrData,
  input logic [NUM_SRC-1:0] enMask,
  input logic [NUM_SRC-1:0] irqReq
);
  logic [NUM_SRC-1:0][1:0] modeSh;
  logic [1:0]              age;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSh <= '0;
      age    <= '0;
    end else begin
      if (cfgWrEn) modeSh <= cfgWrData[2*NUM_SRC-1:0];
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R3 R4
    lvl_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (age == 2'd3 && enMask[i] && !modeSh[i][1])
        |-> irqReq[i] == ($past(pinIn[i], 2) ^ modeSh[i][0]));

    // R5 R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (modeSh[i][1] && enMask[i] && $past(irqReq[i])
        && !$past(clrWrEn && clrWrData[i]) && !$past(cfgWrEn))
        |-> irqReq[i]);

    // R10
    mode_chg_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(cfgWrEn) && ($past(cfgWrData[2*i +: 2]) != $past(modeSh[i]))
        && modeSh[i][1])
        |-> !irqReq[i]);

    // R11
    en_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqReq[i]) |-> enMask[i]);
  end
endmodule

bind irq_trigger_cond irq_trigger_cond_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pinIn     (pinIn),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .clrWrEn   (clrWrEn),
  .clrWrData (clrWrData),
  .enMask    (enMask),
  .irqReq    (irqReq)
);

// File: tb/irq_trigger_cond_tb.sv
module irq_trigger_cond_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  pinIn = '0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        clrWrEn = 1'b0;
  logic [31:0] clrWrData = '0;
  logic [3:0]  enMask = 4'hF;
  logic [3:0]  irqReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] val;
    logic [3:0] mask;
    string      tag;
  } exp_item_t;

  exp_item_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_trigger_cond u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .clrWrEn(clrWrEn), .clrWrData(clrWrData),
    .enMask(enMask), .irqReq(irqReq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectReq(input logic [3:0] v, input logic [3:0] m, input string t);
    exp_item_t it;
    it.val = v; it.mask = m; it.tag = t;
    expQ.push_back(it);
  endtask

  task automatic writeCfg(input logic [31:0] d);
    cfgWrData = d; cfgWrEn = 1'b1;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic writeClr(input logic [31:0] d);
    clrWrData = d; clrWrEn = 1'b1;
    tick(1);
    clrWrEn = 1'b0;
  endtask

  // Monitor: compare queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        exp_item_t it;
        it = expQ.pop_front();
        checks++;
        if ((irqReq & it.mask) !== (it.val & it.mask)) begin
          fails++;
          $display("FAIL %s: irqReq=%b expected=%b (mask %b)",
                   it.tag, irqReq & it.mask, it.val & it.mask, it.mask);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    expectReq(4'b0000, 4'hF, "R1 reset idle");
    tick(1);
    pinIn[0] = 1'b1;
    tick(1);
    expectReq(4'b0000, 4'b0001, "R3 one edge not enough");
    tick(1);
    expectReq(4'b0001, 4'b0001, "R1 R3 high level after two edges");
    tick(1);
    pinIn[0] = 1'b0;
    tick(2);
    expectReq(4'b0000, 4'b0001, "R3 high level drops");
    tick(1);

    // src0 high, src1 low, src2 rise, src3 fall; junk in reserved bits
    writeCfg(32'hFFFF_FFE4);
    expectReq(4'b0010, 4'hF, "R2 R4 modes by field");
    tick(1);

    pinIn = 4'b1110;
    tick(1);
    expectReq(4'b0010, 4'b0010, "R4 low level still held");
    tick(1);
    expectReq(4'b0000, 4'b0110, "R4 R5 two edges in");
    tick(1);
    expectReq(4'b0100, 4'hF, "R5 rise captured on third edge");
    tick(1);

    pinIn = 4'b0000;
    tick(3);
    expectReq(4'b1110, 4'hF, "R5 R6 rise held, fall captured");
    tick(1);

    writeClr(32'h0000_000A);
    expectReq(4'b0110, 4'hF, "R7 R8 clear src3, level src1 untouched");
    tick(1);

    writeClr(32'h0000_0004);
    expectReq(4'b0000, 4'b0100, "R7 clear src2");
    tick(1);
    pinIn[2] = 1'b1;
    tick(2);
    clrWrData = 32'h0000_0004; clrWrEn = 1'b1;
    tick(1);
    clrWrEn = 1'b0;
    expectReq(4'b0100, 4'b0100, "R9 edge beats clear");
    tick(1);
    writeClr(32'h0000_0004);
    expectReq(4'b0000, 4'b0100, "R7 later clear works");
    tick(1);

    pinIn[3] = 1'b1;
    tick(3);
    expectReq(4'b0000, 4'b1000, "R6 rise ignored in fall mode");
    tick(1);
    pinIn[3] = 1'b0;
    enMask = 4'b0111;
    tick(3);
    expectReq(4'b0000, 4'b1000, "R11 disabled source silent");
    tick(1);
    enMask = 4'hF;
    expectReq(4'b1000, 4'b1000, "R11 capture shows on enable");
    tick(1);

    writeCfg(32'h0000_00E4);
    expectReq(4'b1000, 4'b1000, "R10 R2 same fields keep capture");
    tick(1);
    writeCfg(32'h0000_00A4);
    expectReq(4'b0000, 4'b1000, "R10 mode change drops capture");
    tick(3);
    expectReq(4'b0000, 4'b1000, "R10 no false edge after change");
    tick(1);

    pinIn[0] = 1'b1;
    tick(2);
    expectReq(4'b0001, 4'b0001, "R3 high level again");
    tick(1);
    writeCfg(32'h0000_00A6);
    expectReq(4'b0000, 4'b0001, "R10 into rise with pin high");
    tick(3);
    expectReq(4'b0000, 4'b0001, "R10 steady pin reports nothing");
    tick(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule